// File: doc/BRIEF.md
# Blocked Prefix-Sum Sequencer

This controller steers a lane-parallel running-sum datapath across an input array whose length is a whole number of lane groups. The datapath has four lanes by default. Each group of lanes takes three cycles. In the first cycle the group is loaded from the input array, and the carry from the previous group is folded into lane 0. In the next two cycles the lanes add in shifted copies of themselves, first shifted by one lane and then by two.

The controller produces the load strobe, the shift code and two base indices. The load base selects which input elements enter the lanes. The store base selects where the lane registers are written in the output array. From the second group onward, the load of a new group and the store of the finished group happen in the same cycle. After the last group it raises a done flag. A one-cycle register turns that flag into the `ready` seen by the outside world, so every output write has landed before `ready` shows.

The array length must stay constant while a run is in progress. A new run starts only through reset.

Top module: `prefix_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs are: `load_o`=1, `shift_o`=0, `ld_base_o`=0, `st_base_o`=0, `done_flag_o`=0, `ready_o`=0.
- R2: Each group uses three consecutive cycles. The first is a load cycle (`load_o`=1, `shift_o`=0). The second has `shift_o`=1, which means shift by one lane and add. The third has `shift_o`=2, which means shift by two lanes and add. `load_o` is 1 only when `shift_o` is 0.
- R3: `ld_base_o` is 0 for the first group. It grows by exactly the lane count (4) at each later load, and it holds its value through a group's shift cycles.
- R4: In every load cycle after the first, `st_base_o` equals `ld_base_o` minus 4. This is the base of the group that has just been completed.
- R5: After the last shift-by-two cycle, the controller enters done and remains there until reset. In done, `load_o`=0, `shift_o`=0 (hold), `done_flag_o`=1, `st_base_o` = `len_i`−4, and `ld_base_o` stays at `len_i`−4.
- R6: `ready_o` equals `done_flag_o` delayed by one clock cycle.
- R7: Cycles are counted with the first cycle after reset release as cycle 1. For length m, `done_flag_o` first reads 1 in cycle 3·(m/4)+1: cycle 4 for m=4 and cycle 7 for m=8.
- R8: Reset is asynchronous. Asserting it between clock edges at once restores the R1 outputs, including `ready_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| len_i | input | LEN_W | Array length m, a multiple of LANES, held during a run |
| load_o | output | 1 | Parallel load of a lane group (with carry into lane 0) |
| shift_o | output | SHW | 0 = load or hold; k = shift by 2^(k-1) lanes and add |
| ld_base_o | output | LEN_W | Base index of the input group being loaded |
| st_base_o | output | LEN_W | Base index of the output group being written |
| done_flag_o | output | 1 | Internal completion flag (done state) |
| ready_o | output | 1 | Completion flag delayed by one cycle |

## Verification
Several rules are checked by assertions on every cycle. These are: a load coincides with a zero shift code, the shift codes climb one step at a time, the load base only ever steps by the lane count, the store base trails the load base in every later load, done is never left, and `ready_o` follows the flag one cycle later. Other behaviour can only be shown by the directed scenarios. They cover the exact cycle in which completion appears for each length. They show the absolute index values in each phase, including the final store base in done. They also show that a reset asserted between edges takes effect at once, in the middle of a run and after completion.

// File: rtl/prefix_seq_pkg.sv
package prefix_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_FIRST = 2'd0,   // first group load, no store pending
      SEQ_LOAD  = 2'd1,   // load of next group overlapped with store of previous
      SEQ_SHIFT = 2'd2,   // shift-and-add step, step counter selects distance
      SEQ_DONE  = 2'd3    // final store / hold
   } seq_state_e;

endpackage

// File: rtl/prefix_seq_fsm.sv
module prefix_seq_fsm
   import prefix_seq_pkg::*;
#(
   parameter int STEPS = 2,
   parameter int SHW   = 2
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           more_i,
   output logic           load_o,
   output logic [SHW-1:0] shift_o,
   output logic           last_step_o,
   output logic           flag_o
);

   localparam logic [SHW-1:0] STEP_LAST = SHW'(STEPS);
   localparam logic [SHW-1:0] STEP_ONE  = SHW'(1);

   seq_state_e     state_q, state_d;
   logic [SHW-1:0] step_q, step_d;

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      unique case (state_q)
         SEQ_FIRST, SEQ_LOAD: begin
            state_d = SEQ_SHIFT;
            step_d  = STEP_ONE;
         end
         SEQ_SHIFT: begin
            if (step_q == STEP_LAST) begin
               state_d = more_i ? SEQ_LOAD : SEQ_DONE;
               step_d  = '0;
            end else begin
               step_d = step_q + STEP_ONE;
            end
         end
         default: begin
            state_d = SEQ_DONE;
            step_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         state_q <= SEQ_FIRST;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   assign load_o      = (state_q == SEQ_FIRST) || (state_q == SEQ_LOAD);
   assign shift_o     = (state_q == SEQ_SHIFT) ? step_q : '0;
   assign last_step_o = (state_q == SEQ_SHIFT) && (step_q == STEP_LAST);
   assign flag_o      = (state_q == SEQ_DONE);

   // R2
   shift_climb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (shift_o != '0 && shift_o != STEP_LAST) |=> (shift_o == $past(shift_o) + STEP_ONE));

   // R5
   done_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      flag_o |=> (flag_o && !load_o && shift_o == '0));

endmodule

// File: rtl/prefix_seq_index.sv
module prefix_seq_index #(
   parameter int LANES = 4,
   parameter int IDX_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [IDX_W-1:0] len_i,
   input  logic             last_step_i,
   output logic             more_o,
   output logic [IDX_W-1:0] ld_o,
   output logic [IDX_W-1:0] st_o
);

   localparam logic [IDX_W:0]   STRIDE_W = (IDX_W+1)'(LANES);
   localparam logic [IDX_W-1:0] STRIDE   = IDX_W'(LANES);

   logic [IDX_W-1:0] ld_q, st_q;
   logic [IDX_W:0]   next_base;

   assign next_base = {1'b0, ld_q} + STRIDE_W;
   assign more_o    = next_base < {1'b0, len_i};

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         ld_q <= '0;
         st_q <= '0;
      end else if (last_step_i) begin
         st_q <= ld_q;
         if (more_o) begin
            ld_q <= ld_q + STRIDE;
         end
      end
   end

   assign ld_o = ld_q;
   assign st_o = st_q;

   // R3
   ld_stride_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (ld_q != $past(ld_q)) |-> (ld_q == $past(ld_q) + STRIDE));

endmodule

// File: rtl/prefix_seq_ready.sv
module prefix_seq_ready (
   input  logic clk_i,
   input  logic rst_i,
   input  logic flag_i,
   output logic ready_o
);

   logic ready_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) ready_q <= 1'b0;
      else       ready_q <= flag_i;
   end

   assign ready_o = ready_q;

   // R6
   ready_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ##1 (ready_o == $past(flag_i)));

endmodule

// File: rtl/prefix_seq_ctrl.sv
module prefix_seq_ctrl #(
   parameter int LANES = 4,
   parameter int LEN_W = 16,
   localparam int STEPS = $clog2(LANES),
   localparam int SHW   = $clog2(STEPS + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             load_o,
   output logic [SHW-1:0]   shift_o,
   output logic [LEN_W-1:0] ld_base_o,
   output logic [LEN_W-1:0] st_base_o,
   output logic             done_flag_o,
   output logic             ready_o
);

   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("prefix_seq_ctrl: LANES must be a power of two >= 2");
      end
      if (LEN_W <= STEPS) begin : g_bad_len
         $error("prefix_seq_ctrl: LEN_W too narrow for LANES");
      end
   endgenerate

   logic more, last_step;

   prefix_seq_fsm #(.STEPS(STEPS), .SHW(SHW)) fsm_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .more_i      (more),
      .load_o      (load_o),
      .shift_o     (shift_o),
      .last_step_o (last_step),
      .flag_o      (done_flag_o)
   );

   prefix_seq_index #(.LANES(LANES), .IDX_W(LEN_W)) index_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .len_i       (len_i),
      .last_step_i (last_step),
      .more_o      (more),
      .ld_o        (ld_base_o),
      .st_o        (st_base_o)
   );

   prefix_seq_ready ready_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .flag_i  (done_flag_o),
      .ready_o (ready_o)
   );

   // R2
   load_noshift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load_o |-> (shift_o == '0));

   // R4
   store_trails_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (load_o && ld_base_o != '0) |-> (st_base_o == ld_base_o - LEN_W'(LANES)));

endmodule

// File: tb/prefix_seq_ctrl_tb.sv
module prefix_seq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] len = 16'd4;
   logic        load;
   logic [1:0]  shift;
   logic [15:0] ld_base, st_base;
   logic        flag, ready;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prefix_seq_ctrl dut_i (
      .clk_i       (clk),
      .rst_i       (rst),
      .len_i       (len),
      .load_o      (load),
      .shift_o     (shift),
      .ld_base_o   (ld_base),
      .st_base_o   (st_base),
      .done_flag_o (flag),
      .ready_o     (ready)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      // R1: values while reset is held
      chk("R1 load in reset", int'(load), 1);
      chk("R1 ready in reset", int'(ready), 0);
      @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   // one full run of length m, every cycle compared against the schedule
   task automatic run_len(input int m);
      int blocks, last, first_flag;
      len = 16'(m);
      do_reset();
      blocks = m / 4;
      last = 3 * blocks;
      first_flag = 0;
      for (int c = 1; c <= last + 3; c++) begin
         if (c > 1) begin
            @(posedge clk);
            @(negedge clk);
            #1;
         end
         if (c == 1) begin
            chk("R1 ld after release", int'(ld_base), 0);
            chk("R1 flag after release", int'(flag), 0);
         end
         if (c <= last) begin
            int blk = (c - 1) / 3;
            int ph  = (c - 1) % 3;
            chk($sformatf("R2 load m=%0d c=%0d", m, c), int'(load), (ph == 0) ? 1 : 0);
            chk($sformatf("R2 shift m=%0d c=%0d", m, c), int'(shift), ph);
            chk($sformatf("R3 ld m=%0d c=%0d", m, c), int'(ld_base), 4 * blk);
            chk($sformatf("R4 st m=%0d c=%0d", m, c), int'(st_base), (blk == 0) ? 0 : 4 * (blk - 1));
            chk($sformatf("R7 flag low m=%0d c=%0d", m, c), int'(flag), 0);
         end else begin
            chk($sformatf("R5 load m=%0d c=%0d", m, c), int'(load), 0);
            chk($sformatf("R5 shift m=%0d c=%0d", m, c), int'(shift), 0);
            chk($sformatf("R5 st m=%0d c=%0d", m, c), int'(st_base), m - 4);
            chk($sformatf("R5 ld m=%0d c=%0d", m, c), int'(ld_base), m - 4);
            chk($sformatf("R5 flag m=%0d c=%0d", m, c), int'(flag), 1);
         end
         if (flag && first_flag == 0) first_flag = c;
         chk($sformatf("R6 ready m=%0d c=%0d", m, c), int'(ready), (c > last + 1) ? 1 : 0);
      end
      // R7: completion cycle
      chk($sformatf("R7 first done cycle m=%0d", m), first_flag, last + 1);
   endtask

   task automatic reset_mid_run();
      len = 16'd16;
      do_reset();
      repeat (5) @(posedge clk);
      @(negedge clk);
      #2;
      rst = 1'b1;
      #1;
      chk("R8 load after async reset", int'(load), 1);
      chk("R8 shift after async reset", int'(shift), 0);
      chk("R8 ld after async reset", int'(ld_base), 0);
      chk("R8 st after async reset", int'(st_base), 0);
      chk("R8 flag after async reset", int'(flag), 0);
   endtask

   task automatic reset_after_done();
      run_len(4);
      #2;
      rst = 1'b1;
      #1;
      chk("R8 ready cleared by async reset", int'(ready), 0);
      chk("R8 flag cleared by async reset", int'(flag), 0);
      chk("R8 st cleared by async reset", int'(st_base), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      run_len(4);
      run_len(8);
      run_len(12);
      run_len(16);
      reset_mid_run();
      reset_after_done();
      run_len(32);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule